// File: doc/BRIEF.md
# Shortened Reed-Solomon Byte Encoder (204,188)

This block turns a stream of fixed-length transport packets into systematic Reed-Solomon codewords. A source offers one byte per cycle together with a valid flag and a start flag that marks the sync byte of each packet. The encoder forwards the 188 packet bytes unchanged and one cycle late. Straight after the last data byte it appends 16 check bytes, which makes a 204-byte codeword that can repair up to 8 corrupted bytes at the receiver.

The check bytes are the remainder of the packet polynomial, shifted up by 16 places, divided by a degree-16 generator over GF(256). The code is a 255/239 code with its leading 51 information symbols fixed at zero. The division is done one byte per cycle by a ring of 16 byte registers with constant field multipliers in the feedback path. While the check bytes are being emitted, the block lowers its ready output so that the upstream stage can insert its idle slots.

Top module: `rsShortEncoder`

## Requirements
- R1: A byte accepted with inStart high opens a packet, whatever its value (for example 0x47 or 0xB8). Each accepted data byte appears on outData on the next cycle with outValid high and its value unchanged. outStart is high only alongside the first byte.
- R2: The 16 check bytes are the remainder of x^16·m(x) divided by g(x) = (x+a^0)(x+a^1)...(x+a^15). The first packet byte is the coefficient of the highest power of m(x). a = 0x02 in the field built on x^8+x^4+x^3+x^2+1 (0x11D). The check bytes are emitted starting with the x^15 coefficient.
- R3: The check bytes follow the last data byte on 16 consecutive cycles with outValid and outParity high and outStart low. outParity is low on every data byte.
- R4: An accepted byte with inStart high clears the remainder. This also applies in the middle of a packet, where the partial packet is abandoned and a fresh count begins.
- R5: A cycle with inValid low changes neither the byte count nor the remainder, and the next cycle shows outValid low.
- R6: inReady is low for exactly the 16 check-byte cycles. Bytes offered then, including ones with inStart high, are ignored, so each codeword is exactly 204 output bytes.
- R7: With no packet open, a byte offered without inStart is dropped and produces no output.
- R8: After reset, outValid is low and inReady is high.
- R9: Each complete 204-byte codeword evaluates to zero at every root a^0 through a^15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | inData holds a byte this cycle |
| inStart | input | 1 | The offered byte is the packet's sync byte |
| inData | input | 8 | Packet byte |
| inReady | output | 1 | Low while check bytes are emitted; bytes offered then are ignored |
| outValid | output | 1 | outData holds a codeword byte |
| outStart | output | 1 | First byte of a codeword |
| outParity | output | 1 | outData is a check byte |
| outData | output | 8 | Codeword byte |

## Verification
A corrupted remainder register does not show up while data bytes are passing through. It appears only in the 16 check bytes, starting two cycles after the last data byte, and every codeword after that can carry the wrong value. For this reason the check bytes are compared with a division model and also tested through all 16 syndromes. A count that drifts moves outParity away from output position 188 and changes the codeword length, which the per-packet byte count detects. A missed clear at a restarted packet shows up only in that packet's check bytes.

// File: rtl/rsEncPkg.sv
package rsEncPkg;

  localparam int SYM_W    = 8;
  localparam int PAR_LEN  = 16;
  localparam logic [SYM_W:0] FIELD_POLY = 9'h11D;

  typedef logic [SYM_W-1:0] sym_t;

  // control strobes handed from the sequencer to the datapath
  typedef struct packed {
    logic loadByte;   // feed inData into the divider and forward it
    logic clearRem;   // treat remainder as zero for this byte
    logic markStart;  // byte is first of a codeword
    logic shiftPar;   // shift one check byte out
  } encStrobe_t;

  // generator coefficients, index i multiplies x^i (x^16 term is 1)
  localparam sym_t GEN_COEF [PAR_LEN] = '{
    8'd59,  8'd36,  8'd50,  8'd98,  8'd229, 8'd41, 8'd65,  8'd163,
    8'd8,   8'd30,  8'd209, 8'd68,  8'd189, 8'd104, 8'd13, 8'd59
  };

  function automatic sym_t gfMul(input sym_t opA, input sym_t opB);
    sym_t acc;
    sym_t run;
    acc = '0;
    run = opA;
    for (int i = 0; i < SYM_W; i++) begin
      if (opB[i]) acc = acc ^ run;
      run = run[SYM_W-1] ? ((run << 1) ^ FIELD_POLY[SYM_W-1:0]) : (run << 1);
    end
    return acc;
  endfunction

endpackage

// File: rtl/rsEncCtrl.sv
module rsEncCtrl
  import rsEncPkg::*;
#(
  parameter int DATA_LEN = 188
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inStart,
  output logic       inReady,
  output encStrobe_t strobe
);

  localparam int CNT_W = $clog2(DATA_LEN);
  localparam int PC_W  = $clog2(PAR_LEN);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_LEN - 1);
  localparam logic [PC_W-1:0]  LAST_PAR  = PC_W'(PAR_LEN - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_PARITY} encState_t;

  encState_t        state;
  logic [CNT_W-1:0] dataCnt;
  logic [PC_W-1:0]  parCnt;
  logic             accept;

  assign inReady = (state != ST_PARITY);
  assign accept  = inValid && inReady;

  always_comb begin
    strobe.loadByte  = accept && (inStart || state == ST_DATA);
    strobe.clearRem  = accept && inStart;
    strobe.markStart = accept && inStart;
    strobe.shiftPar  = (state == ST_PARITY);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      dataCnt <= '0;
      parCnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept && inStart) begin
            state   <= ST_DATA;
            dataCnt <= CNT_W'(1);
          end
        end
        ST_DATA: begin
          if (accept) begin
            if (inStart) begin
              dataCnt <= CNT_W'(1);
            end else if (dataCnt == LAST_DATA) begin
              state  <= ST_PARITY;
              parCnt <= '0;
            end else begin
              dataCnt <= dataCnt + CNT_W'(1);
            end
          end
        end
        ST_PARITY: begin
          parCnt <= parCnt + PC_W'(1);
          if (parCnt == LAST_PAR) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DATA && !inValid) |=> ($stable(dataCnt) && state == ST_DATA));

  // R6
  parity_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PARITY && parCnt != LAST_PAR) |=> (state == ST_PARITY && !inReady));

endmodule

// File: rtl/rsEncDatapath.sv
module rsEncDatapath
  import rsEncPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  encStrobe_t strobe,
  input  sym_t       inData,
  output logic       outValid,
  output logic       outStart,
  output logic       outParity,
  output sym_t       outData
);

  logic [PAR_LEN-1:0][SYM_W-1:0] rem;
  logic [PAR_LEN-1:0][SYM_W-1:0] remNext;
  sym_t feedback;

  assign feedback = inData ^ (strobe.clearRem ? '0 : rem[PAR_LEN-1]);

  for (genvar i = 0; i < PAR_LEN; i++) begin : g_tap
    if (i == 0) begin : g_low
      assign remNext[i] = strobe.shiftPar ? '0
                        : strobe.loadByte ? gfMul(feedback, GEN_COEF[i])
                        : rem[i];
    end else begin : g_up
      assign remNext[i] = strobe.shiftPar ? rem[i-1]
                        : strobe.loadByte ? ((strobe.clearRem ? '0 : rem[i-1])
                                             ^ gfMul(feedback, GEN_COEF[i]))
                        : rem[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rem       <= '0;
      outValid  <= 1'b0;
      outStart  <= 1'b0;
      outParity <= 1'b0;
      outData   <= '0;
    end else begin
      rem       <= remNext;
      outValid  <= strobe.loadByte || strobe.shiftPar;
      outStart  <= strobe.markStart;
      outParity <= strobe.shiftPar;
      outData   <= strobe.shiftPar ? rem[PAR_LEN-1] : inData;
    end
  end

  // R3
  parity_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    outParity |-> (outValid && !outStart));

  // R3
  parity_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outParity) |-> ($past(rem) == '0));

endmodule

// File: rtl/rsShortEncoder.sv
module rsShortEncoder
  import rsEncPkg::*;
#(
  parameter int DATA_LEN = 188
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inStart,
  input  logic [7:0] inData,
  output logic       inReady,
  output logic       outValid,
  output logic       outStart,
  output logic       outParity,
  output logic [7:0] outData
);

  encStrobe_t strobe;

  rsEncCtrl #(.DATA_LEN(DATA_LEN)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inStart (inStart),
    .inReady (inReady),
    .strobe  (strobe)
  );

  rsEncDatapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inData    (inData),
    .outValid  (outValid),
    .outStart  (outStart),
    .outParity (outParity),
    .outData   (outData)
  );

  // R1
  start_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inStart) |=> (outValid && outStart && outData == $past(inData)));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && inReady) |=> !outValid);

endmodule

// File: tb/rsShortEncoder_bench.sv
module rsShortEncoder_bench;

  localparam int DLEN = 188;
  localparam int PLEN = 16;
  localparam int CLEN = DLEN + PLEN;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic       inStart = 1'b0;
  logic [7:0] inData = '0;
  logic       inReady, outValid, outStart, outParity;
  logic [7:0] outData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rsShortEncoder #(.DATA_LEN(DLEN)) u_rsShortEncoder (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inStart(inStart), .inData(inData),
    .inReady(inReady), .outValid(outValid), .outStart(outStart),
    .outParity(outParity), .outData(outData)
  );

  logic [7:0] gen [PLEN+1];
  logic [7:0] expPkt [DLEN];
  logic [7:0] obuf [CLEN];
  int  obIdx = 0;
  int  outCount = 0;
  int  pktsDone = 0;
  bit  flagBad = 0;
  bit  monOn = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] xtime(input logic [7:0] v);
    return {v[6:0], 1'b0} ^ (v[7] ? 8'h1D : 8'h00);
  endfunction

  function automatic logic [7:0] bMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      p = xtime(p);
      if (b[i]) p = p ^ a;
    end
    return p;
  endfunction

  function automatic logic [7:0] bPow(input int e);
    logic [7:0] r = 8'h01;
    for (int i = 0; i < e; i++) r = xtime(r);
    return r;
  endfunction

  // generator built from its roots, not from a coefficient table
  task automatic buildGen();
    logic [7:0] nx [PLEN+1];
    for (int k = 0; k <= PLEN; k++) gen[k] = (k == 0) ? 8'h01 : 8'h00;
    for (int i = 0; i < PLEN; i++) begin
      logic [7:0] root = bPow(i);
      for (int k = 0; k <= PLEN; k++)
        nx[k] = bMul(gen[k], root) ^ ((k > 0) ? gen[k-1] : 8'h00);
      for (int k = 0; k <= PLEN; k++) gen[k] = nx[k];
    end
  endtask

  task automatic refParity(output logic [7:0] par [PLEN]);
    logic [7:0] r [PLEN];
    logic [7:0] f;
    for (int k = 0; k < PLEN; k++) r[k] = 8'h00;
    for (int n = 0; n < DLEN; n++) begin
      f = expPkt[n] ^ r[PLEN-1];
      for (int k = PLEN-1; k > 0; k--) r[k] = r[k-1] ^ bMul(f, gen[k]);
      r[0] = bMul(f, gen[0]);
    end
    for (int k = 0; k < PLEN; k++) par[k] = r[PLEN-1-k];
  endtask

  task automatic finishPacket();
    logic [7:0] par [PLEN];
    int badData = 0;
    int badPar = 0;
    int firstPar = -1;
    int badSyn = 0;
    refParity(par);
    for (int n = 0; n < DLEN; n++) if (obuf[n] !== expPkt[n]) badData++;
    for (int k = 0; k < PLEN; k++) if (obuf[DLEN+k] !== par[k]) begin
      badPar++;
      if (firstPar < 0) firstPar = k;
    end
    check(badData == 0, "R1 data bytes differ", badData, 0);
    check(badPar == 0, "R2 check bytes", (firstPar < 0) ? 0 : obuf[DLEN+firstPar],
          (firstPar < 0) ? 0 : par[firstPar]);
    for (int j = 0; j < PLEN; j++) begin
      logic [7:0] s = 8'h00;
      logic [7:0] aj = bPow(j);
      for (int n = 0; n < CLEN; n++) s = bMul(s, aj) ^ obuf[n];
      if (s != 8'h00) badSyn++;
    end
    check(badSyn == 0, "R9 nonzero syndromes", badSyn, 0);
    check(!flagBad, "R3 start/parity flag placement", flagBad, 0);
    pktsDone++;
  endtask

  always @(negedge clk) begin
    if (monOn && outValid) begin
      outCount++;
      if (outStart) begin
        obIdx = 0;
        flagBad = 0;
      end
      if (obIdx < CLEN) begin
        if (outParity !== (obIdx >= DLEN)) flagBad = 1;
        if (outStart !== (obIdx == 0)) flagBad = 1;
        obuf[obIdx] = outData;
      end
      obIdx++;
      if (obIdx == CLEN) finishPacket();
    end
  end

  // pattern: 0 zeros, 1 random, 2 all ones, 3 counting
  task automatic sendPacket(input logic [7:0] sync, input int pattern,
                            input bit junkInParity, input int abortAt, input bit gaps);
    int cnt0 = outCount;
    int done0 = pktsDone;
    expPkt[0] = sync;
    for (int n = 1; n < DLEN; n++)
      case (pattern)
        0: expPkt[n] = 8'h00;
        1: expPkt[n] = 8'($urandom);
        2: expPkt[n] = 8'hFF;
        default: expPkt[n] = 8'(n);
      endcase
    // R4: partial packet abandoned by a new start
    for (int n = 0; n < abortAt; n++) begin
      inValid = 1; inStart = (n == 0); inData = 8'($urandom);
      @(negedge clk);
    end
    for (int n = 0; n < DLEN; n++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        inValid = 0; inStart = 0; inData = 8'($urandom);
        @(negedge clk);
        check(outValid === 1'b0, "R5 output during stall", outValid, 0);
      end
      inValid = 1; inStart = (n == 0); inData = expPkt[n];
      @(negedge clk);
    end
    if (junkInParity) begin
      for (int k = 0; k < PLEN; k++) begin
        check(inReady === 1'b0, "R6 ready during check bytes", inReady, 0);
        inValid = 1; inStart = k[0]; inData = 8'($urandom);
        @(negedge clk);
      end
    end
    inValid = 0; inStart = 0;
    while (!inReady) @(negedge clk);
    repeat (3) @(negedge clk);
    check(outCount - cnt0 == CLEN + abortAt, "R6 codeword length", outCount - cnt0,
          CLEN + abortAt);
    check(pktsDone == done0 + 1, "R3 codeword completed", pktsDone - done0, 1);
  endtask

  initial begin
    void'($urandom(32'd20250611));
    buildGen();
    repeat (3) @(negedge clk);
    // R8
    check(outValid === 1'b0, "R8 outValid after reset", outValid, 0);
    check(inReady === 1'b1, "R8 inReady after reset", inReady, 1);
    rstN = 1;
    monOn = 1;
    @(negedge clk);
    // R7: byte without start while idle
    inValid = 1; inStart = 0; inData = 8'hA5;
    @(negedge clk);
    check(outValid === 1'b0, "R7 idle byte dropped", outValid, 0);
    inValid = 0;
    @(negedge clk);
    sendPacket(8'hB8, 0, 0, 0, 0);   // R2 all-zero payload
    sendPacket(8'h47, 1, 0, 0, 1);   // R1 random with gaps
    sendPacket(8'h47, 2, 1, 0, 0);   // R6 junk during parity
    sendPacket(8'hB8, 3, 0, 37, 1);  // R4 restart mid-packet
    sendPacket(8'h47, 1, 1, 187, 0); // R4 restart at last data position
    for (int p = 0; p < 6; p++)
      sendPacket(($urandom % 8 == 0) ? 8'hB8 : 8'h47, 1, p[0], 0, 1);
    // R7 again after a codeword
    inValid = 1; inStart = 0; inData = 8'h3C;
    @(negedge clk);
    check(outValid === 1'b0, "R7 idle byte after codeword", outValid, 0);
    inValid = 0;
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule